// File: doc/BRIEF.md
# Data-Driven Group Clock Gater

This block clocks a small bank of flip-flops only when the bank's contents would change. Each bit of the incoming word is compared with the value the bank already holds. The per-bit difference flags are ORed into one group enable. That enable is caught in a level-sensitive latch while the clock is low, so it stays steady for the whole high phase. It is then combined with the clock to form the single clock that drives the multi-bit register.

When no bit would change, no clock pulse is spent on the bank. The group size is a parameter, so the cost of the one latch and the one gate is shared over 2, 4, 8 or 16 flip-flops. In this cycle-level model, the gated clock is represented as a register enable that comes from the latch.

Four wrapping counters report clock activity:
- every clock edge;
- every edge that clocked the group;
- edges where every bit toggled, which are fully useful pulses;
- edges where only some of the bits toggled, which are partly wasted pulses.

Choosing which flip-flops belong to a group is left to the surrounding design.

Top module: `dd_group_gater`

## Requirements
- R1: While `rst_ni` is low, `q_o` and all four counters read zero. A release of `rst_ni` takes effect only after two rising clock edges, and no register or counter changes on those two edges.
- R2: The first rising edge after the reset release clocks the group unconditionally, so `q_o` takes `d_i` even if `d_i` is all zero. This edge counts as an enabled edge.
- R3: After that first edge, `q_o` takes `d_i` at any rising edge where at least one bit of `d_i` differs from `q_o`.
- R4: At a rising edge where `d_i` equals `q_o`, apart from the first edge after the reset release, `q_o` holds every bit and `cnt_enabled_o` does not advance.
- R5: `cnt_total_o` advances by one at every rising edge after the reset release, and wraps modulo 2^CNT_W.
- R6: `cnt_enabled_o` advances by one at every edge that clocks the group, counting both the forced first edge and the data-driven edges, and wraps modulo 2^CNT_W.
- R7: `cnt_full_o` advances by one at an edge where every bit of `d_i` differs from `q_o`.
- R8: `cnt_partial_o` advances by one at an edge where at least one bit of `d_i` differs from `q_o`, but not all of them do.
- R9: The group width equals the parameter `GROUP_K`, which must be 2, 4, 8 or 16. `d_i` and `q_o` are both `GROUP_K` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock before gating |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised to the clock |
| d_i | input | GROUP_K | Next data for the flip-flop group |
| q_o | output | GROUP_K | Contents of the group register |
| cnt_total_o | output | CNT_W | Count of clock edges since reset |
| cnt_enabled_o | output | CNT_W | Count of edges on which the group was clocked |
| cnt_full_o | output | CNT_W | Count of edges on which every bit toggled |
| cnt_partial_o | output | CNT_W | Count of edges on which some, but not all, bits toggled |

## Verification
Every result is due one rising edge after the data that causes it. `d_i` is applied on the falling edge, the enable latch passes it during the low phase, and both the group register and the counters update at the next rising edge. The bench drives each new word on a falling edge and updates its reference model for that coming edge. It then compares `q_o` and all four counters shortly after the rising edge. The two-edge reset synchroniser is allowed for by letting two rising edges pass after the release before the first modelled edge.

// File: rtl/dd_gate_pkg.sv
package dd_gate_pkg;

  // Result of comparing next data against stored data for one group
  typedef struct packed {
    logic any_diff;   // at least one bit would change
    logic all_diff;   // every bit would change
  } cmp_sum_t;

  function automatic logic size_ok(input int unsigned k);
    return (k == 2) || (k == 4) || (k == 8) || (k == 16);
  endfunction

endpackage

// File: rtl/dd_mismatch.sv
module dd_mismatch
  import dd_gate_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] d_i,
  input  logic [K-1:0] q_i,
  output cmp_sum_t     sum_o
);

  logic [K-1:0] diff_w;

  // one comparator per flip-flop of the group
  for (genvar b = 0; b < K; b++) begin : g_bit
    assign diff_w[b] = d_i[b] ^ q_i[b];
  end

  always_comb begin
    sum_o.any_diff = |diff_w;
    sum_o.all_diff = &diff_w;
  end

endmodule

// File: rtl/dd_en_latch.sv
module dd_en_latch (
  input  logic clk_i,
  input  logic en_d_i,
  output logic en_q_o
);

  // transparent while the clock is low, closed while it is high
  always_latch begin
    if (!clk_i) en_q_o = en_d_i;
  end

endmodule

// File: rtl/dd_group_reg.sv
module dd_group_reg #(
  parameter int unsigned K = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_en_i,
  input  logic [K-1:0] d_i,
  output logic [K-1:0] q_o
);

  logic [K-1:0] q_d;
  logic [K-1:0] q_q;

  always_comb begin
    q_d = q_q;
    if (gate_en_i) q_d = d_i;
  end

  // single multi-bit register behind one gated clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/dd_activity_cnt.sv
module dd_activity_cnt
  import dd_gate_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_en_i,
  input  cmp_sum_t      sum_i,
  output logic [CW-1:0] total_o,
  output logic [CW-1:0] enabled_o,
  output logic [CW-1:0] full_o,
  output logic [CW-1:0] partial_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] total_d, enabled_d, full_d, partial_d;
  logic [CW-1:0] total_q, enabled_q, full_q, partial_q;
  logic          partial_hit;

  assign partial_hit = sum_i.any_diff & ~sum_i.all_diff;

  always_comb begin
    total_d   = total_q + ONE;
    enabled_d = enabled_q;
    full_d    = full_q;
    partial_d = partial_q;
    if (gate_en_i)      enabled_d = enabled_q + ONE;
    if (sum_i.all_diff) full_d    = full_q + ONE;
    if (partial_hit)    partial_d = partial_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q   <= '0;
      enabled_q <= '0;
      full_q    <= '0;
      partial_q <= '0;
    end else begin
      total_q   <= total_d;
      enabled_q <= enabled_d;
      full_q    <= full_d;
      partial_q <= partial_d;
    end
  end

  assign total_o   = total_q;
  assign enabled_o = enabled_q;
  assign full_o    = full_q;
  assign partial_o = partial_q;

endmodule

// File: rtl/dd_group_gater.sv
module dd_group_gater
  import dd_gate_pkg::*;
#(
  parameter int unsigned GROUP_K = 4,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GROUP_K-1:0] d_i,
  output logic [GROUP_K-1:0] q_o,
  output logic [CNT_W-1:0]   cnt_total_o,
  output logic [CNT_W-1:0]   cnt_enabled_o,
  output logic [CNT_W-1:0]   cnt_full_o,
  output logic [CNT_W-1:0]   cnt_partial_o
);

  logic [1:0]   rst_sync_q;
  logic         rst_n_int;
  logic         prime_q;
  logic         en_d;
  logic         en_l;
  cmp_sum_t     sum_w;
  logic [GROUP_K-1:0] q_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // forces one enabled edge after reset so the group loads real data
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) prime_q <= 1'b1;
    else            prime_q <= 1'b0;
  end

  dd_mismatch #(.K(GROUP_K)) u_cmp (
    .d_i   (d_i),
    .q_i   (q_w),
    .sum_o (sum_w)
  );

  assign en_d = sum_w.any_diff | prime_q;

  dd_en_latch u_lat (
    .clk_i  (clk_i),
    .en_d_i (en_d),
    .en_q_o (en_l)
  );

  dd_group_reg #(.K(GROUP_K)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .gate_en_i (en_l),
    .d_i       (d_i),
    .q_o       (q_w)
  );

  dd_activity_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .gate_en_i (en_l),
    .sum_i     (sum_w),
    .total_o   (cnt_total_o),
    .enabled_o (cnt_enabled_o),
    .full_o    (cnt_full_o),
    .partial_o (cnt_partial_o)
  );

  assign q_o = q_w;

endmodule

// File: rtl/dd_group_gater_chk.sv
module dd_group_gater_chk #(
  parameter int unsigned K  = 4,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          prime,
  input logic [K-1:0]  d_i,
  input logic [K-1:0]  q_o,
  input logic [CW-1:0] cnt_total_o,
  input logic [CW-1:0] cnt_enabled_o,
  input logic [CW-1:0] cnt_full_o,
  input logic [CW-1:0] cnt_partial_o
);

  initial begin
    assert_size_R9: assert (dd_gate_pkg::size_ok(K))
      else $error("group size %0d not supported", K);
  end

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (prime || (d_i != q_o)) |=> (q_o == $past(d_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!prime && (d_i == q_o)) |=> ($stable(q_o) && $stable(cnt_enabled_o)));

  assert_total_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (cnt_total_o == CW'($past(cnt_total_o) + 1'b1)));

  assert_full_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (d_i == ~q_o) |=> ((cnt_full_o == CW'($past(cnt_full_o) + 1'b1))
                       && $stable(cnt_partial_o)));

  assert_partial_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((d_i != q_o) && (d_i != ~q_o)) |=>
      ((cnt_partial_o == CW'($past(cnt_partial_o) + 1'b1)) && $stable(cnt_full_o)));

endmodule

bind dd_group_gater dd_group_gater_chk #(.K(GROUP_K), .CW(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n_int),
  .prime         (prime_q),
  .d_i           (d_i),
  .q_o           (q_o),
  .cnt_total_o   (cnt_total_o),
  .cnt_enabled_o (cnt_enabled_o),
  .cnt_full_o    (cnt_full_o),
  .cnt_partial_o (cnt_partial_o)
);

// File: tb/tb_dd_group_gater.sv
`timescale 1ns/1ps
module tb_dd_group_gater;

  localparam int K  = 4;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [K-1:0]  d_i;
  logic [K-1:0]  q_o;
  logic [CW-1:0] cnt_total_o, cnt_enabled_o, cnt_full_o, cnt_partial_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [K-1:0]  m_q;
  logic          m_prime;
  logic [CW-1:0] m_tot, m_en, m_full, m_part;

  always #5 clk_i = ~clk_i;

  dd_group_gater #(.GROUP_K(K), .CNT_W(CW)) dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .d_i           (d_i),
    .q_o           (q_o),
    .cnt_total_o   (cnt_total_o),
    .cnt_enabled_o (cnt_enabled_o),
    .cnt_full_o    (cnt_full_o),
    .cnt_partial_o (cnt_partial_o)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "q_o",           q_o,           m_q);
    chk(req, "cnt_total_o",   cnt_total_o,   m_tot);
    chk(req, "cnt_enabled_o", cnt_enabled_o, m_en);
    chk(req, "cnt_full_o",    cnt_full_o,    m_full);
    chk(req, "cnt_partial_o", cnt_partial_o, m_part);
  endtask

  task automatic model_reset();
    m_q = '0; m_prime = 1'b1;
    m_tot = '0; m_en = '0; m_full = '0; m_part = '0;
  endtask

  // drive d on the falling edge, model the coming rising edge, sample after it
  task automatic step(input logic [K-1:0] d, input string req);
    logic [K-1:0] mm;
    @(negedge clk_i);
    d_i = d;
    mm = d ^ m_q;
    m_tot = m_tot + 1'b1;
    if (m_prime || (mm != '0)) begin
      m_en = m_en + 1'b1;
      m_q  = d;
    end
    if (mm == '1) m_full = m_full + 1'b1;
    else if (mm != '0) m_part = m_part + 1'b1;
    m_prime = 1'b0;
    @(posedge clk_i);
    #1;
    chk_all(req);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    d_i = 4'b1010;
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    chk_all("R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk_all("R1 sync edge 1");
    @(posedge clk_i); #1;
    chk_all("R1 sync edge 2");
  endtask

  task automatic t_prime_zero();
    // d equals the reset value, yet the first edge must be enabled
    t_reset_with(4'b0000);
    step(4'b0000, "R2 forced load");
    chk("R6", "enabled after prime", cnt_enabled_o, 1);
  endtask

  task automatic t_reset_with(input logic [K-1:0] d);
    rst_ni = 1'b0;
    d_i = d;
    model_reset();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
  endtask

  task automatic t_single_toggle();
    step(4'b0001, "R3 one bit");
    step(4'b0011, "R3 second bit");
    step(4'b0010, "R8 partial");
  endtask

  task automatic t_idle();
    step(4'b0010, "R4 idle");
    step(4'b0010, "R4 idle again");
    chk("R4", "q held", q_o, 4'b0010);
  endtask

  task automatic t_all_toggle();
    step(4'b1101, "R7 all toggle");
    step(4'b0010, "R7 all toggle back");
  endtask

  task automatic t_mixed();
    logic [K-1:0] v = 4'b0110;
    for (int i = 0; i < 40; i++) begin
      v = (i % 5 == 0) ? v : {v[2:0], v[3] ^ v[2] ^ 1'b1};
      step(v, "R6 mixed");
    end
  endtask

  task automatic t_wrap();
    // keep toggling all bits so every counter but partial crosses 2^CW
    for (int i = 0; i < 300; i++) begin
      step(~m_q, "R5 wrap");
    end
  endtask

  task automatic t_width();
    chk("R9", "width of q_o", $bits(q_o), K);
    chk("R9", "width of d_i", $bits(d_i), K);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    step(4'b1010, "R2 first edge");
    t_single_toggle();
    t_idle();
    t_all_toggle();
    t_mixed();
    t_prime_zero();
    t_wrap();
    t_width();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule